// File: doc/BRIEF.md
# Reset-Latched Configuration Shadow Bank

This block keeps two copies of each configuration word. Software or a boot-time loader writes the hook copy through a simple local port. The hook copy sets the value that the live copy takes up on the next bus reset. The live copy drives the bus target and cannot be written from the local port. Live values change only while the bus reset input is held high. On each of those clock edges the live copy takes the hook contents. Hook contents survive bus resets. Only a power-on reset returns them to their built-in defaults.

The bank also holds a configuration-done bit that gates whether the target may answer requests. A strap input chooses the reset value of this bit. With the strap high, the bit comes up clear and the target stays silent until the loader sets it. With the strap low, the target answers at once using the default values. The bank also holds a small status field set by hardware events. Software clears status bits by writing ones, or forces them through a write-only port. A matching interrupt-enable field has separate set and clear addresses. The block raises an interrupt request when an enabled status bit is pending.

Top module: `cfg_shadow_bank`

## Requirements
- R1: While `por` is high at a clock edge, every hook and live word takes its default from `HOOK_DEF` (word i at bits [i*DW +: DW]), and status and enable are cleared to zero.
- R2: While `por` is high, the done bit takes the inverse of `autoload_strap`. `respond_en` is high only when the done bit is 1 and `bus_rst` is low.
- R3: The done register at byte 0x50 is read/write in bit 0. Writing 1 allows the target to respond, and writing 0 blocks it again.
- R4: Hook word i is read/write at byte 0x00 + 4*i. Its contents change only through local writes or `por`, so a bus reset leaves them unchanged.
- R5: Live word i reads at byte 0x20 + 4*i and appears on `live_cfg`. Local writes to it are ignored. At each edge where `bus_rst` is high, it takes the value that the hook word held before that edge. At every other edge it stays unchanged.
- R6: The status field at byte 0x40 is read/write-1-to-clear. A bit that is high on `stat_evt` sets the matching status bit. If an event and a clear hit the same bit in the same cycle, the event wins and the bit ends up 1.
- R7: The byte 0x4C is write-only. Writing ones there sets the matching status bits, and a read of 0x4C returns zero.
- R8: Writing ones to byte 0x44 sets interrupt-enable bits, and writing ones to byte 0x48 clears them. A read of either address returns the enable field.
- R9: `host_irq` is high exactly when some status bit and its enable bit are both 1.
- R10: Byte 0x54 is read-only and returns `ID_VALUE`, and writes to it are ignored. An unmapped address reads as zero, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| bus_rst | input | 1 | Bus reset level; copies hook words into live words |
| autoload_strap | input | 1 | Chooses the done-bit reset value |
| wr_en | input | 1 | Local write strobe |
| addr | input | AW | Local byte address |
| wdata | input | DW | Local write data |
| rdata | output | DW | Local read data, combinational on addr |
| stat_evt | input | SW | Hardware status set pulses |
| live_cfg | output | NREG*DW | Live words seen by the target |
| respond_en | output | 1 | Target may answer requests |
| host_irq | output | 1 | Enabled status pending |

## Verification
The bench writes to the hook words while a bus reset is in progress. A design that copied the newly written value in the same edge, rather than the old one, would show the wrong live word one cycle too early. The bench also writes to the live and ID addresses. A bank that accepted those writes would change words that should be read-only. The bench fires status events in the same cycle as write-1-to-clear writes, so a design that let the clear win would lose an event. Both strap settings are exercised. A done bit with the wrong reset value would let the target answer before loading had finished, or would leave the target silent for good.

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
  parameter int NREG = 4,
  parameter int DW = 32,
  parameter int SW = 8,
  parameter int AW = 8,
  parameter logic [DW-1:0] ID_VALUE = 32'hC0DE_0001,
  parameter logic [NREG*DW-1:0] HOOK_DEF = {32'h1234_5678, 32'h0000_0102, 32'hFFFF_0000, 32'h0A0B_0C0D}
) (
  input  logic               clk,
  input  logic               por,
  input  logic               bus_rst,
  input  logic               autoload_strap,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic [SW-1:0]      stat_evt,
  output logic [NREG*DW-1:0] live_cfg,
  output logic               respond_en,
  output logic               host_irq
);
  localparam int WIW = AW - 2;
  localparam int LIVE_W = 8;
  localparam int STAT_W = 16;
  localparam int ENS_W = 17;
  localparam int ENC_W = 18;
  localparam int FRC_W = 19;
  localparam int DONE_W = 20;
  localparam int ID_W = 21;

  logic [NREG*DW-1:0] hook_q;
  logic [NREG*DW-1:0] live_q;
  logic [SW-1:0]      status_q;
  logic [SW-1:0]      inten_q;
  logic               done_q;
  logic [WIW-1:0]     wi;

  assign wi = addr[AW-1:2];

  function automatic logic hit(input logic [WIW-1:0] w, input int idx);
    return int'(w) == idx;
  endfunction

  logic [SW-1:0] clr_bits, frc_bits;
  assign clr_bits = (wr_en && hit(wi, STAT_W)) ? wdata[SW-1:0] : '0;
  assign frc_bits = (wr_en && hit(wi, FRC_W)) ? wdata[SW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (por) begin
      hook_q   <= HOOK_DEF;
      live_q   <= HOOK_DEF;
      status_q <= '0;
      inten_q  <= '0;
      done_q   <= ~autoload_strap;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_en && hit(wi, i)) hook_q[i*DW +: DW] <= wdata;
      if (bus_rst) live_q <= hook_q;
      status_q <= (status_q & ~clr_bits) | stat_evt | frc_bits;
      if (wr_en && hit(wi, ENS_W)) inten_q <= inten_q | wdata[SW-1:0];
      else if (wr_en && hit(wi, ENC_W)) inten_q <= inten_q & ~wdata[SW-1:0];
      if (wr_en && hit(wi, DONE_W)) done_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit(wi, i)) rdata = hook_q[i*DW +: DW];
      if (hit(wi, LIVE_W + i)) rdata = live_q[i*DW +: DW];
    end
    if (hit(wi, STAT_W)) rdata = DW'(status_q);
    if (hit(wi, ENS_W) || hit(wi, ENC_W)) rdata = DW'(inten_q);
    if (hit(wi, DONE_W)) rdata = DW'(done_q);
    if (hit(wi, ID_W)) rdata = ID_VALUE;
  end

  assign live_cfg   = live_q;
  assign respond_en = done_q & ~bus_rst;
  assign host_irq   = |(status_q & inten_q);
endmodule

module cfg_shadow_bank_chk #(
  parameter int NREG = 4,
  parameter int DW = 32,
  parameter int SW = 8,
  parameter int AW = 8
) (
  input logic               clk,
  input logic               por,
  input logic               bus_rst,
  input logic               autoload_strap,
  input logic               wr_en,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      wdata,
  input logic [SW-1:0]      stat_evt,
  input logic               respond_en,
  input logic [NREG*DW-1:0] live_cfg,
  input logic [NREG*DW-1:0] hook_q,
  input logic [SW-1:0]      status_q,
  input logic [SW-1:0]      inten_q
);
  // R2
  strap_hold_chk: assert property (@(posedge clk) (por && autoload_strap) |=> !respond_en);
  // R5
  live_hold_chk: assert property (@(posedge clk) disable iff (por) !bus_rst |=> $stable(live_cfg));
  // R5
  live_copy_chk: assert property (@(posedge clk) disable iff (por) bus_rst |=> live_cfg == $past(hook_q));
  // R4
  hook_hold_chk: assert property (@(posedge clk) disable iff (por) !wr_en |=> $stable(hook_q));
  // R6
  evt_set_chk: assert property (@(posedge clk) disable iff (por)
    (stat_evt != '0) |=> ((status_q & $past(stat_evt)) == $past(stat_evt)));
  // R8
  en_clr_chk: assert property (@(posedge clk) disable iff (por)
    (wr_en && addr[AW-1:2] == (AW-2)'(18)) |=> ((inten_q & $past(wdata[SW-1:0])) == '0));
endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk #(.NREG(NREG), .DW(DW), .SW(SW), .AW(AW)) chk_i (
  .clk(clk), .por(por), .bus_rst(bus_rst), .autoload_strap(autoload_strap),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .stat_evt(stat_evt),
  .respond_en(respond_en), .live_cfg(live_cfg), .hook_q(hook_q),
  .status_q(status_q), .inten_q(inten_q));

// File: tb/cfg_shadow_bank_tb_top.sv
module cfg_shadow_bank_tb_top;
  localparam int NREG = 4, DW = 32, SW = 8, AW = 8;
  localparam logic [DW-1:0] IDV = 32'hC0DE_0001;
  localparam logic [NREG*DW-1:0] DEF = {32'h1234_5678, 32'h0000_0102, 32'hFFFF_0000, 32'h0A0B_0C0D};

  logic clk = 0, por = 0, bus_rst = 0, strap = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [SW-1:0] stat_evt = '0;
  logic [NREG*DW-1:0] live_cfg;
  logic respond_en, host_irq;

  always #2.5 clk = ~clk;

  cfg_shadow_bank dut_i (.clk(clk), .por(por), .bus_rst(bus_rst), .autoload_strap(strap),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .stat_evt(stat_evt),
    .live_cfg(live_cfg), .respond_en(respond_en), .host_irq(host_irq));

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  logic [DW-1:0] m_hook [NREG];
  logic [DW-1:0] m_live [NREG];
  logic [SW-1:0] m_stat, m_en;
  logic m_done;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mread(input int w);
    if (w < NREG) return m_hook[w];
    if (w >= 8 && w < 8 + NREG) return m_live[w-8];
    case (w)
      16: return DW'(m_stat);
      17, 18: return DW'(m_en);
      20: return DW'(m_done);
      21: return IDV;
      default: return '0;
    endcase
  endfunction

  function automatic string rtag(input int w);
    if (w < NREG) return "R4";
    if (w >= 8 && w < 8 + NREG) return "R5";
    case (w)
      16: return "R6";
      17, 18: return "R8";
      19: return "R7";
      20: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic cyc(input bit p, input bit br, input bit w, input int wi,
                     input logic [DW-1:0] d, input logic [SW-1:0] ev);
    logic [DW-1:0] oh [NREG];
    por = p; bus_rst = br; wr_en = w; addr = AW'(wi * 4); wdata = d; stat_evt = ev;
    #1;
    if (!p) begin
      chk(rtag(wi), rdata, mread(wi));
      chk("R2", DW'(respond_en), DW'(m_done & ~br));
      chk("R9", DW'(host_irq), DW'(|(m_stat & m_en)));
      for (int i = 0; i < NREG; i++) chk("R5", live_cfg[i*DW +: DW], m_live[i]);
    end
    @(posedge clk);
    if (p) begin
      for (int i = 0; i < NREG; i++) begin
        m_hook[i] = DEF[i*DW +: DW];
        m_live[i] = DEF[i*DW +: DW];
      end
      m_stat = '0; m_en = '0; m_done = ~strap;
    end else begin
      for (int i = 0; i < NREG; i++) oh[i] = m_hook[i];
      if (w && wi < NREG) m_hook[wi] = d;
      if (br) for (int i = 0; i < NREG; i++) m_live[i] = oh[i];
      m_stat = (m_stat & ~((w && wi == 16) ? d[SW-1:0] : '0)) | ev | ((w && wi == 19) ? d[SW-1:0] : '0);
      if (w && wi == 17) m_en = m_en | d[SW-1:0];
      if (w && wi == 18) m_en = m_en & ~d[SW-1:0];
      if (w && wi == 20) m_done = d[0];
    end
    @(negedge clk);
  endtask

  task automatic rd(input int wi);
    cyc(0, 0, 0, wi, '0, '0);
  endtask

  initial begin
    #(5ns * 200000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    @(negedge clk);
    // R1 R2: strap high -> done clear, target silent
    strap = 1;
    cyc(1, 0, 0, 0, '0, '0); cyc(1, 0, 0, 0, '0, '0);
    for (int i = 0; i < NREG; i++) begin rd(i); rd(8 + i); end
    chk("R1", DW'(live_cfg[DW-1:0]), 32'h0A0B_0C0D);
    chk("R2", DW'(respond_en), 0);
    rd(16); rd(17); rd(20);
    // R3: loader sets done
    cyc(0, 0, 1, 20, 32'h1, '0);
    chk("R3", DW'(respond_en), 1);
    rd(20);
    cyc(0, 0, 1, 20, 32'h0, '0);
    chk("R3", DW'(respond_en), 0);
    // R5: live write ignored, copy during bus reset uses old hook
    cyc(0, 0, 1, 8, 32'hDEAD_BEEF, '0); rd(8);
    cyc(0, 0, 1, 1, 32'h5555_AAAA, '0);
    cyc(0, 1, 1, 1, 32'h7777_0000, '0);
    chk("R5", live_cfg[DW +: DW], 32'h5555_AAAA);
    cyc(0, 1, 0, 1, '0, '0);
    chk("R5", live_cfg[DW +: DW], 32'h7777_0000);
    rd(1); rd(9);
    // R6: event beats clear in same cycle
    cyc(0, 0, 0, 0, '0, 8'h0F);
    cyc(0, 0, 1, 16, 32'h03, 8'h01);
    rd(16);
    chk("R6", DW'(dut_i.rdata), 32'h0D);
    // R7: force, write-only reads zero
    cyc(0, 0, 1, 19, 32'hF0, '0); rd(19); rd(16);
    // R8 R9
    cyc(0, 0, 1, 17, 32'h81, '0); rd(17);
    cyc(0, 0, 1, 18, 32'h01, '0); rd(18);
    // R10: ID read-only, unmapped ignored
    cyc(0, 0, 1, 21, 32'h0, '0); rd(21);
    cyc(0, 0, 1, 5, 32'hFFFF_FFFF, '0); rd(5); rd(23);
    // R2: strap low -> immediate response
    strap = 0;
    cyc(1, 0, 0, 0, '0, '0);
    rd(20);
    chk("R2", DW'(respond_en), 1);
    for (int n = 0; n < 4000; n++) begin
      int wi;
      bit w, br;
      logic [DW-1:0] d;
      wi = int'($urandom % 24);
      w = ($urandom % 2) == 0;
      br = ($urandom % 12) == 0;
      d = (wi == 20) ? DW'($urandom % 2) : DW'($urandom);
      cyc(0, br, w, wi, d, (($urandom % 4) == 0) ? SW'($urandom) : '0);
    end
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule